// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupts

This block is a memory-mapped general-purpose I/O controller that serves three banks of 32 pins each. Software reaches it over a simple single-cycle bus with a 32-bit data path. Per bank it holds a direction mask, an input-inversion mask, an output latch and four trigger-enable masks. Dedicated set and clear addresses let software change single output bits without a read-modify-write.

Pad inputs are resynchronized through two flops and then optionally inverted. Each pin can then raise rising-edge, falling-edge, high-level or low-level events, in any combination. These events are latched into a per-bank pending register that software clears by writing ones. A companion register shows which pending bits came from edges. One interrupt line serves all banks.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: After synchronous reset every register reads zero, `pins_out` and `pins_oe` are all zero and `irq` is low.
- R2: The address is decoded as register group in `bus_addr[7:4]` and bank in `bus_addr[3:2]`, with `bus_addr[1:0]` ignored. The groups are 0x0 direction, 0x1 polarity, 0x2 data, 0x3 set, 0x4 clear, 0x5 rising enable, 0x6 falling enable, 0x7 high enable, 0x8 low enable, 0x9 pending and 0xA edge flags. Bank field 3 or group 0xB..0xF reads as zero, and writes there change nothing.
- R3: A write to the data group loads the output latch. In the set group a one bit drives that output high, and in the clear group a one bit drives it low. Zero bits leave outputs unchanged, and both groups read as zero. `pins_out` follows the latch one clock after the write.
- R4: A direction bit of 1 makes the pin an output: the matching `pins_oe` bit is 1.
- R5: Reading the data group returns the output latch for output pins. For input pins it returns the synchronized pad value, which reflects a pad change after two clock edges.
- R6: A polarity bit of 1 inverts the sensed pad value before any edge or level detection.
- R7: An enabled rising or falling edge of the sensed value sets the pending bit on the third clock edge after the pad change. With both edge enables set, either edge triggers. An edge-caused pending bit stays set until software clears it.
- R8: While an enabled level condition (sensed high or sensed low) holds, its pending bit sets again on the cycle after a clear.
- R9: Writing ones to the pending group clears only those bits. An event in the same cycle as a clear wins, and the bit stays set.
- R10: The edge-flag group shows which pending bits were set by edge events. The flags clear together with the pending bits, and writes to the edge-flag group are ignored.
- R11: `irq` is the OR over all banks of the pending bits whose pin has at least one trigger enabled. Disabling all triggers of a pin drops its contribution but keeps the pending bit readable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| pins_in | input | 96 | Pad input values, bank 0 in the low 32 bits |
| pins_out | output | 96 | Output latch values |
| pins_oe | output | 96 | Output enables |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench sweeps the set and clear addresses over every bit of every bank. A decoder that mixed up banks or touched neighbouring bits would corrupt the other outputs. It times a clear write to land in the same cycle as a fresh edge; a design that lets the clear win would lose that interrupt. Level triggers are held active across a clear to show that the pending bit comes straight back, while a sticky edge bit must survive the return edge of the pin. It also runs a level trigger under inverted polarity. Finally it disables a pending pin's triggers to show `irq` falling while the pending bit is still readable, and it probes unmapped bank and group codes, which must read zero and must leave every real register alone.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NUM_BANKS  = 3;
    localparam int PIN_W      = 32;
    localparam int ADDR_W     = 8;
    localparam int GRP_W      = 4;
    localparam int GRP_LSB    = 4;
    localparam int BANK_SEL_W = 2;
    localparam int BANK_LSB   = 2;
    localparam int TOTAL_PINS = NUM_BANKS * PIN_W;

    typedef enum logic [GRP_W-1:0] {
        GRP_DIR  = 4'h0,
        GRP_POL  = 4'h1,
        GRP_DATA = 4'h2,
        GRP_SET  = 4'h3,
        GRP_CLR  = 4'h4,
        GRP_REN  = 4'h5,
        GRP_FEN  = 4'h6,
        GRP_HEN  = 4'h7,
        GRP_LEN  = 4'h8,
        GRP_STAT = 4'h9,
        GRP_EDGE = 4'hA
    } reg_grp_e;

    typedef struct packed {
        logic [PIN_W-1:0] rise;
        logic [PIN_W-1:0] fall;
        logic [PIN_W-1:0] high;
        logic [PIN_W-1:0] low;
    } trig_en_t;

    typedef struct packed {
        logic [PIN_W-1:0] dir;
        logic [PIN_W-1:0] pol;
        logic [PIN_W-1:0] dout;
    } pin_cfg_t;

    function automatic logic grp_known(input logic [GRP_W-1:0] g);
        return g <= GRP_W'(GRP_EDGE);
    endfunction

    function automatic logic [PIN_W-1:0] any_trig(input trig_en_t t);
        return t.rise | t.fall | t.high | t.low;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_W-1:0] sensed,
    input  trig_en_t         en,
    output logic [PIN_W-1:0] hit,
    output logic [PIN_W-1:0] edge_hit
);
    logic [PIN_W-1:0] prev_q;
    logic [PIN_W-1:0] rise;
    logic [PIN_W-1:0] fall;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sensed;
    end

    always_comb begin
        rise     = sensed & ~prev_q;
        fall     = ~sensed & prev_q;
        edge_hit = (rise & en.rise) | (fall & en.fall);
        hit      = edge_hit | (sensed & en.high) | (~sensed & en.low);
    end
endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_pkg::*;
(
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    output reg_grp_e             grp,
    output logic [NUM_BANKS-1:0] bank_hit,
    output logic                 rd_en
);
    logic [GRP_W-1:0]      grp_raw;
    logic [BANK_SEL_W-1:0] bidx;
    logic                  ok;

    always_comb begin
        grp_raw = bus_addr[GRP_LSB +: GRP_W];
        bidx    = bus_addr[BANK_LSB +: BANK_SEL_W];
        ok      = bus_sel && grp_known(grp_raw) && (32'(bidx) < NUM_BANKS);
        grp     = reg_grp_e'(grp_raw);
        rd_en   = bus_sel && !bus_we;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
        assign bank_hit[b] = ok && (bidx == BANK_SEL_W'(b));
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_grp_e         grp,
    input  logic [PIN_W-1:0] wdata,
    input  logic [PIN_W-1:0] pad_in,
    output logic [PIN_W-1:0] rdata,
    output logic [PIN_W-1:0] pad_out,
    output logic [PIN_W-1:0] pad_oe,
    output logic [PIN_W-1:0] pend_q,
    output logic [PIN_W-1:0] edge_q,
    output logic             irq_pend
);
    pin_cfg_t         cfg_q;
    trig_en_t         en_q;
    logic [PIN_W-1:0] pad_s;
    logic [PIN_W-1:0] sensed;
    logic [PIN_W-1:0] hit;
    logic [PIN_W-1:0] edge_hit;
    logic [PIN_W-1:0] clr_mask;

    gpio_sync #(.W(PIN_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_s)
    );

    assign sensed = pad_s ^ cfg_q.pol;

    gpio_trig_detect u_det (
        .clk      (clk),
        .rst      (rst),
        .sensed   (sensed),
        .en       (en_q),
        .hit      (hit),
        .edge_hit (edge_hit)
    );

    assign clr_mask = (wr_en && grp == GRP_STAT) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            en_q  <= '0;
        end else if (wr_en) begin
            case (grp)
                GRP_DIR:  cfg_q.dir  <= wdata;
                GRP_POL:  cfg_q.pol  <= wdata;
                GRP_DATA: cfg_q.dout <= wdata;
                GRP_SET:  cfg_q.dout <= cfg_q.dout | wdata;
                GRP_CLR:  cfg_q.dout <= cfg_q.dout & ~wdata;
                GRP_REN:  en_q.rise  <= wdata;
                GRP_FEN:  en_q.fall  <= wdata;
                GRP_HEN:  en_q.high  <= wdata;
                GRP_LEN:  en_q.low   <= wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            edge_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_mask) | hit;
            edge_q <= (edge_q & ~clr_mask) | edge_hit;
        end
    end

    always_comb begin
        case (grp)
            GRP_DIR:  rdata = cfg_q.dir;
            GRP_POL:  rdata = cfg_q.pol;
            GRP_DATA: rdata = (cfg_q.dir & cfg_q.dout) | (~cfg_q.dir & pad_s);
            GRP_REN:  rdata = en_q.rise;
            GRP_FEN:  rdata = en_q.fall;
            GRP_HEN:  rdata = en_q.high;
            GRP_LEN:  rdata = en_q.low;
            GRP_STAT: rdata = pend_q;
            GRP_EDGE: rdata = edge_q;
            default:  rdata = '0;
        endcase
    end

    assign pad_out  = cfg_q.dout;
    assign pad_oe   = cfg_q.dir;
    assign irq_pend = |(pend_q & any_trig(en_q));
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
    import gpio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [PIN_W-1:0]      bus_wdata,
    output logic [PIN_W-1:0]      bus_rdata,
    input  logic [TOTAL_PINS-1:0] pins_in,
    output logic [TOTAL_PINS-1:0] pins_out,
    output logic [TOTAL_PINS-1:0] pins_oe,
    output logic                  irq
);
    reg_grp_e              grp;
    logic [NUM_BANKS-1:0]  bank_hit;
    logic                  rd_en;
    logic [PIN_W-1:0]      bank_rdata [NUM_BANKS];
    logic [NUM_BANKS-1:0]  bank_irq;
    logic [TOTAL_PINS-1:0] stat_flat;
    logic [TOTAL_PINS-1:0] edge_flat;

    gpio_decode u_dec (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .grp      (grp),
        .bank_hit (bank_hit),
        .rd_en    (rd_en)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (bank_hit[b] && bus_we),
            .grp      (grp),
            .wdata    (bus_wdata),
            .pad_in   (pins_in[b*PIN_W +: PIN_W]),
            .rdata    (bank_rdata[b]),
            .pad_out  (pins_out[b*PIN_W +: PIN_W]),
            .pad_oe   (pins_oe[b*PIN_W +: PIN_W]),
            .pend_q   (stat_flat[b*PIN_W +: PIN_W]),
            .edge_q   (edge_flat[b*PIN_W +: PIN_W]),
            .irq_pend (bank_irq[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_en && bank_hit[b]) bus_rdata = bus_rdata | bank_rdata[b];
        end
    end

    assign irq = |bank_irq;
endmodule

// File: rtl/gpio_banked_ctrl_chk.sv
module gpio_banked_ctrl_chk
    import gpio_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_sel,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [PIN_W-1:0]      bus_wdata,
    input logic [PIN_W-1:0]      bus_rdata,
    input logic [TOTAL_PINS-1:0] pins_out,
    input logic [TOTAL_PINS-1:0] pins_oe,
    input logic                  irq,
    input logic [TOTAL_PINS-1:0] stat_flat,
    input logic [TOTAL_PINS-1:0] edge_flat
);
    logic bad_addr;
    logic pend_clr;
    assign bad_addr = (bus_addr[GRP_LSB +: GRP_W] > GRP_W'(GRP_EDGE))
                   || (32'(bus_addr[BANK_LSB +: BANK_SEL_W]) >= NUM_BANKS);
    assign pend_clr = bus_sel && bus_we && (bus_addr[GRP_LSB +: GRP_W] == GRP_W'(GRP_STAT));

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pins_out == '0 && pins_oe == '0 && !irq));

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bad_addr) |-> (bus_rdata == '0));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
        p_set_high_r3: assert property (@(posedge clk) disable iff (rst)
            (bus_sel && bus_we && bus_addr[GRP_LSB +: GRP_W] == GRP_W'(GRP_SET)
             && bus_addr[BANK_LSB +: BANK_SEL_W] == BANK_SEL_W'(b))
            |=> ((pins_out[b*PIN_W +: PIN_W] & $past(bus_wdata)) == $past(bus_wdata)));

        p_clr_low_r3: assert property (@(posedge clk) disable iff (rst)
            (bus_sel && bus_we && bus_addr[GRP_LSB +: GRP_W] == GRP_W'(GRP_CLR)
             && bus_addr[BANK_LSB +: BANK_SEL_W] == BANK_SEL_W'(b))
            |=> ((pins_out[b*PIN_W +: PIN_W] & $past(bus_wdata)) == '0));
    end

    p_edge_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !pend_clr |=> ((edge_flat & $past(edge_flat)) == $past(edge_flat)));

    p_edge_within_pend_r10: assert property (@(posedge clk) disable iff (rst)
        (edge_flat & ~stat_flat) == '0);

    p_irq_has_source_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_flat != '0));
endmodule

bind gpio_banked_ctrl gpio_banked_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pins_out  (pins_out),
    .pins_oe   (pins_oe),
    .irq       (irq),
    .stat_flat (stat_flat),
    .edge_flat (edge_flat)
);

// File: tb/tb_gpio_banked_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_banked_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [95:0] pins_in = '0;
    logic [95:0] pins_out;
    logic [95:0] pins_oe;
    logic        irq;

    int n_cmp = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_banked_ctrl dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pins_in(pins_in), .pins_out(pins_out), .pins_oe(pins_oe), .irq(irq)
    );

    // group codes: 0 dir, 1 pol, 2 data, 3 set, 4 clr, 5 ren, 6 fen, 7 hen, 8 len, 9 pend, A edge
    function automatic logic [7:0] ra(input int grp, input int bank);
        return 8'((grp << 4) | (bank << 2));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic wait3();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int b = 0; b < 3; b++)
            for (int g = 0; g <= 10; g++)
                rd_chk("R1 reg zero", ra(g, b), 32'h0);
        chk("R1 oe", pins_oe[31:0] | pins_oe[63:32] | pins_oe[95:64], 32'h0);
        chk("R1 out", pins_out[31:0] | pins_out[63:32] | pins_out[95:64], 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R3: set/clear sweep over every pin of every bank
        for (int b = 0; b < 3; b++) begin
            for (int i = 0; i < 32; i++) begin
                wr(ra(3, b), 32'd1 << i);
                chk("R3 set bit", pins_out[b*32 +: 32], 32'd1 << i);
                chk("R3 others", pins_out & ~(96'd1 << (b*32 + i)), 32'h0);
                wr(ra(4, b), 32'd1 << i);
                chk("R3 clr bit", pins_out[b*32 +: 32], 32'h0);
            end
        end
        wr(ra(2, 1), 32'hF0F0_1234);
        chk("R3 data load", pins_out[63:32], 32'hF0F0_1234);
        wr(ra(3, 1), 32'h0000_000B);
        chk("R3 set keeps", pins_out[63:32], 32'hF0F0_123F);
        wr(ra(4, 1), 32'hF000_0001);
        chk("R3 clr keeps", pins_out[63:32], 32'h00F0_123E);
        rd_chk("R3 set reads zero", ra(3, 1), 32'h0);
        rd_chk("R3 clr reads zero", ra(4, 1), 32'h0);

        // R4: direction drives output enable
        wr(ra(0, 2), 32'h8000_00FF);
        chk("R4 oe bank2", pins_oe[95:64], 32'h8000_00FF);
        chk("R4 oe bank0", pins_oe[31:0], 32'h0);

        // R5: data read mixes latch and synchronized pad
        wr(ra(0, 0), 32'h0000_FFFF);
        wr(ra(2, 0), 32'hA5A5_A5A5);
        pins_in[31:0] = 32'h3C3C_3C3C;
        repeat (2) @(negedge clk);
        rd_chk("R5 data mix", ra(2, 0), 32'h3C3C_A5A5);
        pins_in[31:0] = 32'h0;
        repeat (2) @(negedge clk);
        rd_chk("R5 data mix after", ra(2, 0), 32'h0000_A5A5);
        wr(ra(0, 0), 32'h0);

        // R2: unmapped addresses and ignored low address bits
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'hB0, 32'hFFFF_FFFF);
        rd_chk("R2 bank3 reads zero", 8'h0C, 32'h0);
        rd_chk("R2 group B reads zero", 8'hB4, 32'h0);
        rd_chk("R2 bank0 dir untouched", ra(0, 0), 32'h0);
        rd_chk("R2 bank1 dir untouched", ra(0, 1), 32'h0);
        wr(8'h07, 32'h0000_0055);
        rd_chk("R2 low bits ignored", ra(0, 1), 32'h0000_0055);
        wr(ra(0, 1), 32'h0);

        // R7: rising edge on bank1 pin5, sticky through the return edge
        wr(ra(5, 1), 32'h20);
        pins_in[37] = 1'b1;
        wait3();
        rd_chk("R7 rise pend", ra(9, 1), 32'h20);
        rd_chk("R10 edge flag", ra(10, 1), 32'h20);
        chk("R11 irq on", {31'h0, irq}, 32'h1);
        pins_in[37] = 1'b0;
        wait3();
        rd_chk("R7 sticky", ra(9, 1), 32'h20);
        wr(ra(10, 1), 32'hFFFF_FFFF);
        rd_chk("R10 write ignored", ra(10, 1), 32'h20);
        wr(ra(9, 1), 32'h20);
        rd_chk("R9 cleared", ra(9, 1), 32'h0);
        rd_chk("R10 flag cleared", ra(10, 1), 32'h0);
        chk("R11 irq off", {31'h0, irq}, 32'h0);
        wr(ra(5, 1), 32'h0);

        // R7: falling edge on bank2 pin7 drives the shared irq
        pins_in[71] = 1'b1;
        wait3();
        wr(ra(6, 2), 32'h80);
        rd_chk("R7 no fall yet", ra(9, 2), 32'h0);
        pins_in[71] = 1'b0;
        wait3();
        rd_chk("R7 fall pend", ra(9, 2), 32'h80);
        chk("R11 shared irq bank2", {31'h0, irq}, 32'h1);
        wr(ra(9, 2), 32'h80);
        wr(ra(6, 2), 32'h0);

        // R7: both edges on bank0 pin0
        wr(ra(5, 0), 32'h1);
        wr(ra(6, 0), 32'h1);
        pins_in[0] = 1'b1;
        wait3();
        rd_chk("R7 both rise", ra(9, 0), 32'h1);
        wr(ra(9, 0), 32'h1);
        rd_chk("R7 both cleared", ra(9, 0), 32'h0);
        pins_in[0] = 1'b0;
        wait3();
        rd_chk("R7 both fall", ra(9, 0), 32'h1);
        wr(ra(9, 0), 32'h1);
        wr(ra(5, 0), 32'h0);
        wr(ra(6, 0), 32'h0);

        // R8: high level on bank0 pin3 re-sets after clear
        wr(ra(7, 0), 32'h8);
        pins_in[3] = 1'b1;
        wait3();
        rd_chk("R8 level pend", ra(9, 0), 32'h8);
        rd_chk("R10 level no edge flag", ra(10, 0), 32'h0);
        wr(ra(9, 0), 32'h8);
        rd_chk("R8 level re-set", ra(9, 0), 32'h8);
        pins_in[3] = 1'b0;
        wait3();
        wr(ra(9, 0), 32'h8);
        rd_chk("R8 level gone", ra(9, 0), 32'h0);
        wr(ra(7, 0), 32'h0);

        // R6: inverted low-level trigger on bank1 pin9
        wr(ra(1, 1), 32'h200);
        wr(ra(8, 1), 32'h200);
        wait3();
        rd_chk("R6 inverted idle", ra(9, 1), 32'h0);
        pins_in[41] = 1'b1;
        wait3();
        rd_chk("R6 inverted fires", ra(9, 1), 32'h200);
        wr(ra(9, 1), 32'h200);
        rd_chk("R8 low level re-set", ra(9, 1), 32'h200);
        pins_in[41] = 1'b0;
        wait3();
        wr(ra(9, 1), 32'h200);
        rd_chk("R6 inverted quiet", ra(9, 1), 32'h0);
        wr(ra(8, 1), 32'h0);
        wr(ra(1, 1), 32'h0);

        // R9: clear only written bits, event beats a same-cycle clear
        wr(ra(5, 2), 32'h6);
        pins_in[65] = 1'b1;
        pins_in[66] = 1'b1;
        wait3();
        rd_chk("R9 two pend", ra(9, 2), 32'h6);
        wr(ra(9, 2), 32'h2);
        rd_chk("R9 only bit1 cleared", ra(9, 2), 32'h4);
        pins_in[65] = 1'b0;
        wait3();
        pins_in[65] = 1'b1;
        @(negedge clk);
        wr(ra(9, 2), 32'h2);
        rd_chk("R9 event wins", ra(9, 2), 32'h6);
        wr(ra(9, 2), 32'h6);
        rd_chk("R9 all cleared", ra(9, 2), 32'h0);
        wr(ra(5, 2), 32'h0);

        // R11: disabling triggers masks irq but keeps pending
        wr(ra(5, 0), 32'h10);
        pins_in[4] = 1'b1;
        wait3();
        chk("R11 irq from bank0", {31'h0, irq}, 32'h1);
        wr(ra(5, 0), 32'h0);
        chk("R11 irq masked", {31'h0, irq}, 32'h0);
        rd_chk("R11 pend kept", ra(9, 0), 32'h10);
        wr(ra(9, 0), 32'h10);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule